// File: doc/BRIEF.md
# Panel Power Sequencer

This block drives the three enables of a flat-panel display in a fixed order: the logic supply rail, the video interface drive, and the backlight inverter. A single level request asks for the panel to be on or off. A one-millisecond tick input supplies the time base. All waits are counted in ticks inside the block, and every minimum and maximum interval on both the rise and fall paths is a parameter checked at elaboration.

On the way up, the supply is enabled first. The block then waits for a supply-good indication and a programmable settle time before it drives the interface. The backlight follows only after a long delay. On the way down, the order is reversed: backlight first, then interface, then supply. The supply then stays off for a minimum hold before any restart. A request that changes mid-sequence is handled by walking back down cleanly. If the supply never reports good, a fault is raised and the rail is dropped.

Waits that guarantee a minimum interval count one extra tick. The first tick after entering a state can arrive at any point within the current millisecond, and the extra tick covers that uncertainty.

Top module: `panel_pwr_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, supply_en, signal_en, backlight_en, busy and fault are all 0.
- R2: A rising panel_on in the idle state sets supply_en and busy one clock later. Once the synchronised supply_good is seen, signal_en rises after exactly SIG_DELAY_MS further ticks (default 20, limited to 1..50).
- R3: backlight_en is 1 only while signal_en and supply_en are both 1. It rises exactly BL_DELAY_MS+1 ticks after signal_en rose (default 201). At that point busy drops to 0.
- R4: panel_on falling while fully on drops backlight_en at once. signal_en falls BL_OFF_GAP_MS ticks later, and supply_en falls SIG_OFF_GAP_MS ticks after that (both default 1).
- R5: After supply_en falls, it stays 0 for OFF_HOLD_MS+1 ticks (default 151), and busy stays 1 through the hold. A panel_on that is high when the hold ends restarts the supply in that same transition.
- R6: If supply_good is not seen within PG_TIMEOUT_MS ticks of supply_en rising (default 10, limited to 1..10), fault rises and supply_en falls together, and the off-hold runs. After the hold the block idles without restarting while panel_on stays high. fault clears one clock after panel_on goes low.
- R7: panel_on falling during power-up walks back down. If the interface is not yet driven, the supply drops after SIG_OFF_GAP_MS ticks. If the interface is driven but the backlight is not yet on, signal_en drops after BL_OFF_GAP_MS ticks and supply_en drops SIG_OFF_GAP_MS ticks later.
- R8: busy is 0 only when the block is idle with all enables off, or when it is fully on.
- R9: signal_en is never 1 while supply_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1ms | input | 1 | One-cycle pulse once per millisecond |
| panel_on | input | 1 | Level request: 1 = panel on, 0 = panel off |
| supply_good | input | 1 | Supply rail reached regulation (asynchronous, synchronised inside) |
| supply_en | output | 1 | Logic supply rail enable |
| signal_en | output | 1 | Video interface drive enable |
| backlight_en | output | 1 | Backlight inverter power enable |
| busy | output | 1 | Sequence in progress |
| fault | output | 1 | Supply-good timeout seen; cleared by dropping the request |

## Verification
The assertions assume that tick_1ms is a single-cycle pulse separated by several clocks, and that panel_on is synchronous to clk. They also assume supply_good settles within the synchroniser's depth, well before the next tick. The stimulus keeps to these limits: it pulses the tick every eight clocks and changes panel_on and supply_good only three clocks after a tick. That way no request change or synchronised supply-good ever meets a tick in the same cycle, and each output edge can be attributed to a known tick index.

// File: rtl/psq_pkg.sv
package psq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SUP_WAIT,
      ST_SIG_DLY,
      ST_BL_DLY,
      ST_ON,
      ST_BL_OFF,
      ST_SIG_OFF,
      ST_HOLD
   } psq_state_e;

   typedef struct packed {
      logic sup;
      logic sig;
      logic bl;
      logic busy;
   } psq_out_t;

   // Enable pattern held by each state.
   function automatic psq_out_t psq_decode(psq_state_e s);
      psq_out_t o;
      o = '0;
      case (s)
         ST_IDLE:     o = '{sup: 1'b0, sig: 1'b0, bl: 1'b0, busy: 1'b0};
         ST_SUP_WAIT: o = '{sup: 1'b1, sig: 1'b0, bl: 1'b0, busy: 1'b1};
         ST_SIG_DLY:  o = '{sup: 1'b1, sig: 1'b0, bl: 1'b0, busy: 1'b1};
         ST_BL_DLY:   o = '{sup: 1'b1, sig: 1'b1, bl: 1'b0, busy: 1'b1};
         ST_ON:       o = '{sup: 1'b1, sig: 1'b1, bl: 1'b1, busy: 1'b0};
         ST_BL_OFF:   o = '{sup: 1'b1, sig: 1'b1, bl: 1'b0, busy: 1'b1};
         ST_SIG_OFF:  o = '{sup: 1'b1, sig: 1'b0, bl: 1'b0, busy: 1'b1};
         ST_HOLD:     o = '{sup: 1'b0, sig: 1'b0, bl: 1'b0, busy: 1'b1};
         default:     o = '0;
      endcase
      return o;
   endfunction

endpackage

// File: rtl/psq_sync.sv
module psq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[STAGES-2:0], d};
         end
         assign q = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/psq_ms_timer.sv
module psq_ms_timer #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clr,
   input  logic          tick,
   input  logic [CW-1:0] lim,
   output logic          done
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || clr)               cnt <= '0;
      else if (tick && cnt != lim)  cnt <= cnt + 1'b1;
   end

   assign done = (cnt == lim);

   // The count never runs past the limit of the state it belongs to.
   assert_cnt_bounded_R2: assert property (@(posedge clk) disable iff (rst)
      (!$past(clr) && $stable(lim)) |-> (cnt <= lim));
endmodule

// File: rtl/psq_fsm.sv
module psq_fsm
   import psq_pkg::*;
#(
   parameter int unsigned PG_TIMEOUT_MS  = 10,
   parameter int unsigned SIG_DELAY_MS   = 20,
   parameter int unsigned BL_DELAY_MS    = 200,
   parameter int unsigned BL_OFF_GAP_MS  = 1,
   parameter int unsigned SIG_OFF_GAP_MS = 1,
   parameter int unsigned OFF_HOLD_MS    = 150,
   parameter int unsigned CW             = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          on_req,
   input  logic          pg,
   input  logic          done,
   output logic          restart,
   output logic [CW-1:0] lim,
   output psq_out_t      out_q,
   output logic          fault_q
);
   psq_state_e st, nxt;
   logic       fault_set;

   always_comb begin
      nxt       = st;
      lim       = '0;
      fault_set = 1'b0;
      case (st)
         ST_IDLE: if (on_req && !fault_q) nxt = ST_SUP_WAIT;
         ST_SUP_WAIT: begin
            lim = CW'(PG_TIMEOUT_MS);
            if (!on_req)   nxt = ST_SIG_OFF;
            else if (pg)   nxt = ST_SIG_DLY;
            else if (done) begin
               nxt       = ST_HOLD;
               fault_set = 1'b1;
            end
         end
         ST_SIG_DLY: begin
            lim = CW'(SIG_DELAY_MS);
            if (!on_req)   nxt = ST_SIG_OFF;
            else if (done) nxt = ST_BL_DLY;
         end
         ST_BL_DLY: begin
            lim = CW'(BL_DELAY_MS + 1);
            if (!on_req)   nxt = ST_BL_OFF;
            else if (done) nxt = ST_ON;
         end
         ST_ON: if (!on_req) nxt = ST_BL_OFF;
         ST_BL_OFF: begin
            lim = CW'(BL_OFF_GAP_MS);
            if (done) nxt = ST_SIG_OFF;
         end
         ST_SIG_OFF: begin
            lim = CW'(SIG_OFF_GAP_MS);
            if (done) nxt = ST_HOLD;
         end
         ST_HOLD: begin
            lim = CW'(OFF_HOLD_MS + 1);
            if (done) nxt = (on_req && !fault_q) ? ST_SUP_WAIT : ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   assign restart = (nxt != st);

   always_ff @(posedge clk) begin
      if (rst) begin
         st      <= ST_IDLE;
         out_q   <= '0;
         fault_q <= 1'b0;
      end else begin
         st    <= nxt;
         out_q <= psq_decode(nxt);
         if (!on_req)        fault_q <= 1'b0;
         else if (fault_set) fault_q <= 1'b1;
      end
   end

   assert_fault_clears_R6: assert property (@(posedge clk) disable iff (rst)
      $fell(on_req) |=> !fault_q);
   assert_busy_idle_R8: assert property (@(posedge clk) disable iff (rst)
      !out_q.busy |-> ((out_q.sup == out_q.sig) && (out_q.sig == out_q.bl)));
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
   import psq_pkg::*;
#(
   parameter int unsigned PG_TIMEOUT_MS  = 10,
   parameter int unsigned SIG_DELAY_MS   = 20,
   parameter int unsigned BL_DELAY_MS    = 200,
   parameter int unsigned BL_OFF_GAP_MS  = 1,
   parameter int unsigned SIG_OFF_GAP_MS = 1,
   parameter int unsigned OFF_HOLD_MS    = 150,
   parameter int unsigned PG_SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic tick_1ms,
   input  logic panel_on,
   input  logic supply_good,
   output logic supply_en,
   output logic signal_en,
   output logic backlight_en,
   output logic busy,
   output logic fault
);
   localparam int unsigned M1 = (PG_TIMEOUT_MS > SIG_DELAY_MS) ? PG_TIMEOUT_MS : SIG_DELAY_MS;
   localparam int unsigned M2 = (BL_DELAY_MS + 1 > OFF_HOLD_MS + 1) ? BL_DELAY_MS + 1 : OFF_HOLD_MS + 1;
   localparam int unsigned M3 = (BL_OFF_GAP_MS > SIG_OFF_GAP_MS) ? BL_OFF_GAP_MS : SIG_OFF_GAP_MS;
   localparam int unsigned M4 = (M1 > M2) ? M1 : M2;
   localparam int unsigned LIM_MAX = (M4 > M3) ? M4 : M3;
   localparam int unsigned CW = $clog2(LIM_MAX + 1);

   // Elaboration-time limits on the timing parameters.
   if (PG_TIMEOUT_MS < 1 || PG_TIMEOUT_MS > 10) begin : g_bad_pg
      $error("PG_TIMEOUT_MS must be 1..10");
   end
   if (SIG_DELAY_MS < 1 || SIG_DELAY_MS > 50) begin : g_bad_sig
      $error("SIG_DELAY_MS must be 1..50");
   end
   if (BL_DELAY_MS < 200) begin : g_bad_bl
      $error("BL_DELAY_MS must be at least 200");
   end
   if (OFF_HOLD_MS < 150) begin : g_bad_hold
      $error("OFF_HOLD_MS must be at least 150");
   end
   if (BL_OFF_GAP_MS < 1 || SIG_OFF_GAP_MS < 1) begin : g_bad_gap
      $error("off gaps must be at least 1");
   end

   logic          pg_s, restart, done;
   logic [CW-1:0] lim;
   psq_out_t      oq;

   psq_sync #(.STAGES(PG_SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(supply_good), .q(pg_s));

   psq_ms_timer #(.CW(CW)) u_tmr (
      .clk(clk), .rst(rst), .clr(restart), .tick(tick_1ms), .lim(lim), .done(done));

   psq_fsm #(
      .PG_TIMEOUT_MS(PG_TIMEOUT_MS), .SIG_DELAY_MS(SIG_DELAY_MS),
      .BL_DELAY_MS(BL_DELAY_MS), .BL_OFF_GAP_MS(BL_OFF_GAP_MS),
      .SIG_OFF_GAP_MS(SIG_OFF_GAP_MS), .OFF_HOLD_MS(OFF_HOLD_MS), .CW(CW)
   ) u_fsm (
      .clk(clk), .rst(rst), .on_req(panel_on), .pg(pg_s), .done(done),
      .restart(restart), .lim(lim), .out_q(oq), .fault_q(fault));

   assign supply_en    = oq.sup;
   assign signal_en    = oq.sig;
   assign backlight_en = oq.bl;
   assign busy         = oq.busy;

   // Interval watchers for the checks below.
   localparam int unsigned OFW = $clog2(OFF_HOLD_MS + 2);
   localparam int unsigned BLW = $clog2(BL_DELAY_MS + 2);
   logic [OFW-1:0] off_ticks;
   logic [BLW-1:0] sig_ticks;

   always_ff @(posedge clk) begin
      if (rst)                                              off_ticks <= OFW'(OFF_HOLD_MS + 1);
      else if (supply_en)                                   off_ticks <= '0;
      else if (tick_1ms && off_ticks != OFW'(OFF_HOLD_MS + 1)) off_ticks <= off_ticks + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst || !signal_en)                                  sig_ticks <= '0;
      else if (tick_1ms && sig_ticks != BLW'(BL_DELAY_MS + 1)) sig_ticks <= sig_ticks + 1'b1;
   end

   assert_bl_order_R3: assert property (@(posedge clk) disable iff (rst)
      backlight_en |-> (signal_en && supply_en));
   assert_bl_delay_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(backlight_en) |-> (sig_ticks > BLW'(BL_DELAY_MS)));
   assert_sig_order_R9: assert property (@(posedge clk) disable iff (rst)
      signal_en |-> supply_en);
   assert_bl_first_R4: assert property (@(posedge clk) disable iff (rst)
      $fell(signal_en) |-> (!backlight_en && $past(!backlight_en)));
   assert_off_hold_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(supply_en) |-> (off_ticks > OFW'(OFF_HOLD_MS)));
   assert_fault_drop_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(fault) |-> (!supply_en && !signal_en && !backlight_en));
endmodule

// File: tb/tb_panel_pwr_seq.sv
module tb_panel_pwr_seq;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tick_1ms = 1'b0;
   logic panel_on = 1'b0;
   logic supply_good = 1'b0;
   logic supply_en, signal_en, backlight_en, busy, fault;

   int n_chk = 0;
   int n_bad = 0;
   int tk = 0;
   logic mon_en = 1'b0;
   logic wd = 1'b0;

   always #10 clk = ~clk;

   panel_pwr_seq dut (
      .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .panel_on(panel_on),
      .supply_good(supply_good), .supply_en(supply_en), .signal_en(signal_en),
      .backlight_en(backlight_en), .busy(busy), .fault(fault));

   // Vector order: {supply_en, signal_en, backlight_en, busy, fault}
   typedef struct {
      logic [4:0] v;
      int         t;
      string      r;
   } exp_t;
   exp_t sb[$];

   function automatic logic [4:0] outs();
      return {supply_en, signal_en, backlight_en, busy, fault};
   endfunction

   task automatic push(input logic [4:0] v, input int t, input string r);
      exp_t e;
      e.v = v; e.t = t; e.r = r;
      sb.push_back(e);
   endtask

   task automatic check(input logic ok, input string r, input string what,
                        input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, expv);
      end
   endtask

   // Tick every 8 clocks; index is bumped before the pulse rises.
   initial begin
      forever begin
         repeat (7) @(negedge clk);
         tk++;
         tick_1ms = 1'b1;
         @(negedge clk);
         tick_1ms = 1'b0;
      end
   end

   task automatic wait_until(input int n);
      while (tk < n) @(posedge tick_1ms);
      repeat (3) @(negedge clk);
   endtask

   // Monitor: every output edge must match the next queued item and tick.
   initial begin
      logic [4:0] prev;
      prev = '0;
      forever begin
         @(negedge clk);
         if (mon_en && outs() !== prev) begin
            if (sb.size() == 0) begin
               check(1'b0, "R8", "unexpected output change", int'(outs()), int'(prev));
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(outs() === e.v, e.r, "output vector", int'(outs()), int'(e.v));
               check(tk == e.t, e.r, "tick of change", tk, e.t);
            end
            prev = outs();
         end
      end
   end

   int T, U, V, F;

   initial begin
      fork
         begin
            repeat (5) @(negedge clk);
            check(outs() === 5'b0, "R1", "outputs in reset", int'(outs()), 0);
            rst = 1'b0;
            @(negedge clk);
            check(outs() === 5'b0, "R1", "outputs after reset", int'(outs()), 0);
            mon_en = 1'b1;

            // Power-up with supply-good two ticks after request.
            wait_until(2);
            T = tk;
            panel_on = 1'b1;
            push(5'b10010, T, "R2");
            wait_until(T + 2);
            supply_good = 1'b1;
            push(5'b11010, T + 22, "R2");
            push(5'b11100, T + 223, "R3");

            // Ordered power-down.
            U = T + 230;
            wait_until(U);
            check(outs() === 5'b11100, "R3", "fully on", int'(outs()), 5'b11100);
            panel_on = 1'b0;
            push(5'b11010, U, "R4");
            push(5'b10010, U + 1, "R4");
            push(5'b00010, U + 2, "R4");
            wait_until(U + 5);
            supply_good = 1'b0;

            // Request during the off-hold is held pending.
            wait_until(U + 50);
            panel_on = 1'b1;
            push(5'b10010, U + 153, "R5");
            wait_until(U + 140);
            check(supply_en === 1'b0 && busy === 1'b1, "R5", "held off while pending",
                  int'(outs()), 5'b00010);
            wait_until(U + 155);
            supply_good = 1'b1;
            push(5'b11010, U + 175, "R2");

            // Abort while waiting for the backlight.
            wait_until(U + 225);
            panel_on = 1'b0;
            push(5'b10010, U + 226, "R7");
            push(5'b00010, U + 227, "R7");
            push(5'b00000, U + 378, "R8");
            wait_until(U + 226);
            supply_good = 1'b0;

            // Abort before the interface is driven.
            V = U + 385;
            wait_until(V);
            panel_on = 1'b1;
            push(5'b10010, V, "R2");
            wait_until(V + 2);
            supply_good = 1'b1;
            wait_until(V + 10);
            panel_on = 1'b0;
            push(5'b00010, V + 11, "R7");
            push(5'b00000, V + 162, "R7");
            wait_until(V + 12);
            supply_good = 1'b0;

            // Supply never reports good.
            F = V + 170;
            wait_until(F);
            panel_on = 1'b1;
            push(5'b10010, F, "R6");
            push(5'b00011, F + 10, "R6");
            push(5'b00001, F + 161, "R6");
            wait_until(F + 165);
            check(supply_en === 1'b0, "R6", "no restart while faulted",
                  int'(supply_en), 0);
            panel_on = 1'b0;
            push(5'b00000, F + 165, "R6");
            wait_until(F + 170);
            check(sb.size() == 0, "R8", "scoreboard drained", sb.size(), 0);
         end
         begin
            repeat (100000) @(posedge clk);
            wd = 1'b1;
         end
      join_any
      disable fork;
      if (wd) check(1'b0, "R1", "watchdog expired", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule